// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge Interface

This block is the guest-facing half of a virtualized interrupt CPU interface for a single virtual CPU. A hypervisor places virtual interrupts into a small bank of list entries through a write port. Each entry carries an interrupt number, a source CPU number, a priority, a lifecycle state, an end-of-interrupt request flag and a hardware-link flag. The hypervisor can also read any entry back through an index/data pair.

The guest sees four 32-bit registers on a simple request port. A global enable sits at offset 0x00, a priority mask at 0x04, an acknowledge register at 0x0C and an end-of-interrupt register at 0x10. Reading the acknowledge register claims the best pending entry and marks it active. Writing the end-of-interrupt register retires the entry that matches the written interrupt and CPU numbers. A level virtual-IRQ output tells the core that something is waiting. Read data and the error flag are combinational and valid in the same cycle as the request. State changes take effect at the closing clock edge.

Top module: `virq_ack_unit`

## Requirements
- R1: After reset every list entry reads 0, the enable and the priority mask are 0, and `virq` is low.
- R2: A hypervisor write stores all 32 bits into the entry named by `hv_idx`, and `hv_rdata` returns the entry named by `hv_ridx`. The entry layout is as follows: interrupt number [9:0], CPU number [12:10], end-of-interrupt request bit 19, priority [27:23], state [29:28] and hardware-link bit 31. The state codes are 0 invalid, 1 pending, 2 active and 3 pending+active.
- R3: An acknowledge read returns 1023 with no error and changes no entry when no entry is pending or the enable is 0.
- R4: An acknowledge read that succeeds returns the chosen entry's interrupt number in [9:0] and its CPU number in [12:10], and sets that entry's state to 2 at the clock edge.
- R5: States 1 and 3 count as pending. Among pending entries the lowest priority value wins, and equal priorities go to the lowest index.
- R6: An end-of-interrupt write takes the interrupt number from [9:0] and the CPU number from [12:10]. It clears to state 0 the lowest-indexed non-invalid entry that matches both. If no entry matches, nothing changes.
- R7: `virq` rises one cycle after an entry is pending while the enable is 1. It falls in the same cycle that no entry is pending any more. Once raised, it stays high while anything is pending, even if the enable is cleared.
- R8: A write to 0x04 stores bits [4:0] as the priority mask. The mask reads back at 0x04 and is visible on `vpri_mask`.
- R9: A write to 0x00 stores bit 0 as the enable, and a read of 0x00 returns it in bit 0.
- R10: If the chosen entry has its hardware-link bit set, an acknowledge read raises `g_err` and returns 0, and the entry keeps its state.
- R11: An access to any other address, a write to 0x0C or a read of 0x10 raises `g_err` and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hv_we | input | 1 | Hypervisor entry write strobe |
| hv_idx | input | IDX_W | Entry index for the write |
| hv_wdata | input | 32 | Entry value to store |
| hv_ridx | input | IDX_W | Entry index for read-back |
| hv_rdata | output | 32 | Entry value at `hv_ridx` |
| vpri_mask | output | 5 | Current virtual priority mask |
| g_req | input | 1 | Guest access request |
| g_we | input | 1 | 1 for a write, 0 for a read |
| g_addr | input | ADDR_W | Guest register offset |
| g_wdata | input | 32 | Guest write data |
| g_rdata | output | 32 | Guest read data (same cycle) |
| g_err | output | 1 | Guest error response (same cycle) |
| virq | output | 1 | Level virtual interrupt to the core |

## Verification
The bench targets the choice among several pending entries: one tie on priority value, one pending+active entry and one entry with a worse priority. A selector that compared the wrong way, or that ignored state 3, would return the acknowledge IDs in the wrong order. End-of-interrupt writes whose interrupt number matches but whose CPU number does not must leave the entry alone; a design that matched on the number alone would clear it. The bench times `virq` edge by edge, including the case where the enable is cleared while the line is high, so an extra register stage or an early drop shows up. Hardware-linked and illegal accesses are checked through the entry read-back to confirm that no state moved.

// File: rtl/vai_pkg.sv
package vai_pkg;

    typedef enum logic [1:0] {
        ST_INVALID  = 2'd0,
        ST_PENDING  = 2'd1,
        ST_ACTIVE   = 2'd2,
        ST_PEND_ACT = 2'd3
    } lr_state_e;

    typedef struct packed {
        logic       hw;
        logic       rsv_hi;
        lr_state_e  state;
        logic [4:0] prio;
        logic [2:0] rsv_mid;
        logic       eoi_req;
        logic [5:0] rsv_lo;
        logic [2:0] cpu;
        logic [9:0] vid;
    } lr_entry_t;

    localparam logic [31:0] SPURIOUS_ID = 32'd1023;

    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_PMASK = 'h04;
    localparam int OFF_ACK   = 'h0C;
    localparam int OFF_EOI   = 'h10;

    function automatic logic is_pending(lr_entry_t e);
        return (e.state == ST_PENDING) || (e.state == ST_PEND_ACT);
    endfunction

    function automatic logic [31:0] ack_word(lr_entry_t e);
        return {19'd0, e.cpu, e.vid};
    endfunction

endpackage

// File: rtl/lr_bank.sv
module lr_bank
    import vai_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int IDX_W  = $clog2(NUM_LR)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hv_we,
    input  logic [IDX_W-1:0]         hv_idx,
    input  lr_entry_t                hv_data,
    input  logic [NUM_LR-1:0]        to_active,
    input  logic [NUM_LR-1:0]        to_invalid,
    output lr_entry_t [NUM_LR-1:0]   lrs
);

    lr_entry_t store_q [NUM_LR];

    for (genvar g = 0; g < NUM_LR; g++) begin : g_entry
        logic hv_hit;
        assign hv_hit = hv_we && (hv_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                store_q[g] <= '0;
            end else if (hv_hit) begin
                store_q[g] <= hv_data;
            end else if (to_active[g]) begin
                store_q[g].state <= ST_ACTIVE;
            end else if (to_invalid[g]) begin
                store_q[g].state <= ST_INVALID;
            end
        end

        assign lrs[g] = store_q[g];

        p_ack_sets_active_r4: assert property (@(posedge clk) disable iff (rst)
            (to_active[g] && !hv_hit) |=> (store_q[g].state == ST_ACTIVE));

        p_eoi_clears_r6: assert property (@(posedge clk) disable iff (rst)
            (to_invalid[g] && !to_active[g] && !hv_hit) |=> (store_q[g].state == ST_INVALID));

        p_idle_holds_r11: assert property (@(posedge clk) disable iff (rst)
            (!hv_hit && !to_active[g] && !to_invalid[g]) |=> $stable(store_q[g]));
    end

endmodule

// File: rtl/lr_select.sv
module lr_select
    import vai_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int IDX_W  = $clog2(NUM_LR)
) (
    input  lr_entry_t [NUM_LR-1:0] lrs,
    input  logic [9:0]             key_vid,
    input  logic [2:0]             key_cpu,
    output logic                   win_valid,
    output logic [IDX_W-1:0]       win_idx,
    output logic                   match_valid,
    output logic [IDX_W-1:0]       match_idx
);

    logic [4:0] best_prio;

    // Best pending entry: strict less-than keeps the lower index on ties.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best_prio = '1;
        for (int i = 0; i < NUM_LR; i++) begin
            if (is_pending(lrs[i]) && (!win_valid || (lrs[i].prio < best_prio))) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                best_prio = lrs[i].prio;
            end
        end
    end

    // Retire lookup: walk downward so the lowest matching index is kept.
    always_comb begin
        match_valid = 1'b0;
        match_idx   = '0;
        for (int i = NUM_LR - 1; i >= 0; i--) begin
            if ((lrs[i].state != ST_INVALID) && (lrs[i].vid == key_vid) &&
                (lrs[i].cpu == key_cpu)) begin
                match_valid = 1'b1;
                match_idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/virq_ack_unit.sv
module virq_ack_unit
    import vai_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int ADDR_W = 8,
    parameter int IDX_W  = $clog2(NUM_LR)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hv_we,
    input  logic [IDX_W-1:0]   hv_idx,
    input  logic [31:0]        hv_wdata,
    input  logic [IDX_W-1:0]   hv_ridx,
    output logic [31:0]        hv_rdata,
    output logic [4:0]         vpri_mask,
    input  logic               g_req,
    input  logic               g_we,
    input  logic [ADDR_W-1:0]  g_addr,
    input  logic [31:0]        g_wdata,
    output logic [31:0]        g_rdata,
    output logic               g_err,
    output logic               virq
);

    lr_entry_t [NUM_LR-1:0] lrs;
    logic [NUM_LR-1:0]      to_active, to_invalid;
    logic                   win_valid, match_valid;
    logic [IDX_W-1:0]       win_idx, match_idx;

    logic       en_q, irq_q;
    logic [4:0] pmask_q;

    logic hit_ctrl, hit_pmask, hit_ack, hit_eoi, unmapped;
    logic rd_ack, wr_eoi, ack_ok, ack_hw;

    lr_bank #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .hv_we      (hv_we),
        .hv_idx     (hv_idx),
        .hv_data    (lr_entry_t'(hv_wdata)),
        .to_active  (to_active),
        .to_invalid (to_invalid),
        .lrs        (lrs)
    );

    lr_select #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_sel (
        .lrs         (lrs),
        .key_vid     (g_wdata[9:0]),
        .key_cpu     (g_wdata[12:10]),
        .win_valid   (win_valid),
        .win_idx     (win_idx),
        .match_valid (match_valid),
        .match_idx   (match_idx)
    );

    always_comb begin
        hit_ctrl  = (g_addr == ADDR_W'(OFF_CTRL));
        hit_pmask = (g_addr == ADDR_W'(OFF_PMASK));
        hit_ack   = (g_addr == ADDR_W'(OFF_ACK));
        hit_eoi   = (g_addr == ADDR_W'(OFF_EOI));
        unmapped  = !(hit_ctrl || hit_pmask || hit_ack || hit_eoi);

        rd_ack = g_req && !g_we && hit_ack;
        wr_eoi = g_req && g_we && hit_eoi;
        ack_ok = rd_ack && en_q && win_valid && !lrs[win_idx].hw;
        ack_hw = rd_ack && en_q && win_valid && lrs[win_idx].hw;

        g_err = g_req && (unmapped || (g_we && hit_ack) || (!g_we && hit_eoi) || ack_hw);

        g_rdata = '0;
        if (g_req && !g_we) begin
            if (hit_ctrl)       g_rdata = {31'd0, en_q};
            else if (hit_pmask) g_rdata = {27'd0, pmask_q};
            else if (hit_ack) begin
                if (ack_ok)      g_rdata = ack_word(lrs[win_idx]);
                else if (!ack_hw) g_rdata = SPURIOUS_ID;
            end
        end

        to_active  = ack_ok ? (NUM_LR'(1) << win_idx) : '0;
        to_invalid = (wr_eoi && match_valid) ? (NUM_LR'(1) << match_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            pmask_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (g_req && g_we && hit_ctrl)  en_q    <= g_wdata[0];
            if (g_req && g_we && hit_pmask) pmask_q <= g_wdata[4:0];
            irq_q <= irq_q ? win_valid : (win_valid && en_q);
        end
    end

    assign virq      = irq_q && win_valid;
    assign vpri_mask = pmask_q;
    assign hv_rdata  = lrs[hv_ridx];

    p_rise_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(virq) |-> $past(en_q));

    p_virq_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (win_valid && en_q && !virq) |=> (virq || !win_valid));

    p_ack_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !en_q) |-> (g_rdata == SPURIOUS_ID && !g_err && to_active == '0));

    p_err_no_update_r10: assert property (@(posedge clk) disable iff (rst)
        g_err |-> (to_active == '0 && to_invalid == '0));

endmodule

// File: tb/tb_virq_ack_unit.sv
module tb_virq_ack_unit;
    import vai_pkg::*;

    localparam int NUM_LR = 4;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              hv_we;
    logic [IDX_W-1:0]  hv_idx, hv_ridx;
    logic [31:0]       hv_wdata, hv_rdata;
    logic [4:0]        vpri_mask;
    logic              g_req, g_we;
    logic [ADDR_W-1:0] g_addr;
    logic [31:0]       g_wdata, g_rdata;
    logic              g_err, virq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    virq_ack_unit #(.NUM_LR(NUM_LR), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst),
        .hv_we(hv_we), .hv_idx(hv_idx), .hv_wdata(hv_wdata),
        .hv_ridx(hv_ridx), .hv_rdata(hv_rdata), .vpri_mask(vpri_mask),
        .g_req(g_req), .g_we(g_we), .g_addr(g_addr), .g_wdata(g_wdata),
        .g_rdata(g_rdata), .g_err(g_err), .virq(virq)
    );

    function automatic logic [31:0] mk(input int vid, input int cpu, input int prio,
                                       input int st, input bit hw = 1'b0);
        return {hw, 1'b0, 2'(st), 5'(prio), 3'd0, 1'b0, 6'd0, 3'(cpu), 10'(vid)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic hv_load(input int idx, input logic [31:0] d);
        @(negedge clk);
        hv_we = 1'b1; hv_idx = IDX_W'(idx); hv_wdata = d;
        @(posedge clk); #1;
        hv_we = 1'b0;
    endtask

    task automatic rd_lr(input int idx, output logic [31:0] v);
        hv_ridx = IDX_W'(idx);
        #1;
        v = hv_rdata;
    endtask

    task automatic gacc(input bit we, input int addr, input logic [31:0] wd,
                        output logic [31:0] rd, output logic err);
        @(negedge clk);
        g_req = 1'b1; g_we = we; g_addr = ADDR_W'(addr); g_wdata = wd;
        #1;
        rd = g_rdata; err = g_err;
        @(posedge clk); #1;
        g_req = 1'b0; g_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v; logic e;
        chk("R1 virq", {31'd0, virq}, 32'd0);
        for (int i = 0; i < NUM_LR; i++) begin
            rd_lr(i, v);
            chk("R1 entry", v, 32'd0);
        end
        chk("R1 mask", {27'd0, vpri_mask}, 32'd0);
        gacc(1'b0, 'h0C, 0, v, e);
        chk("R3 ack idle", v, 32'd1023);
        chk("R3 ack idle err", {31'd0, e}, 32'd0);
    endtask

    task automatic t_ctrl_pmask();
        logic [31:0] v; logic e;
        gacc(1'b0, 'h00, 0, v, e);
        chk("R1 enable", v, 32'd0);
        gacc(1'b1, 'h00, 32'h0000_0001, v, e);
        gacc(1'b0, 'h00, 0, v, e);
        chk("R9 enable read", v, 32'd1);
        gacc(1'b1, 'h04, 32'hFFFF_FF13, v, e);
        gacc(1'b0, 'h04, 0, v, e);
        chk("R8 mask read", v, 32'h13);
        chk("R8 mask port", {27'd0, vpri_mask}, 32'h13);
    endtask

    task automatic t_load_virq();
        logic [31:0] v;
        hv_load(2, mk(45, 3, 8, 1));
        rd_lr(2, v);
        chk("R2 readback", v, mk(45, 3, 8, 1));
        chk("R7 virq not yet", {31'd0, virq}, 32'd0);
        @(posedge clk); #1;
        chk("R7 virq raised", {31'd0, virq}, 32'd1);
    endtask

    task automatic t_select();
        logic [31:0] v; logic e;
        hv_load(0, mk(100, 0, 10, 1));
        hv_load(1, mk(101, 0, 8, 3));
        hv_load(3, mk(103, 1, 8, 1));
        gacc(1'b0, 'h0C, 0, v, e);
        chk("R5 pend+active wins tie", v, 32'd101);
        rd_lr(1, v);
        chk("R4 state active", v, mk(101, 0, 8, 2));
        gacc(1'b0, 'h0C, 0, v, e);
        chk("R4 id with cpu", v, 32'd3117);
        gacc(1'b0, 'h0C, 0, v, e);
        chk("R5 tie lowest index", v, 32'd1127);
        chk("R7 still high", {31'd0, virq}, 32'd1);
        gacc(1'b0, 'h0C, 0, v, e);
        chk("R5 worst prio last", v, 32'd100);
        chk("R7 drops same cycle", {31'd0, virq}, 32'd0);
        gacc(1'b0, 'h0C, 0, v, e);
        chk("R3 none pending", v, 32'd1023);
    endtask

    task automatic t_eoi();
        logic [31:0] v; logic e;
        gacc(1'b1, 'h10, 32'd103, v, e);
        chk("R6 eoi err", {31'd0, e}, 32'd0);
        rd_lr(3, v);
        chk("R6 wrong cpu ignored", v, mk(103, 1, 8, 2));
        gacc(1'b1, 'h10, 32'd1127, v, e);
        rd_lr(3, v);
        chk("R6 retired", v, mk(103, 1, 8, 0));
        rd_lr(2, v);
        chk("R6 other untouched", v, mk(45, 3, 8, 2));
    endtask

    task automatic t_disabled();
        logic [31:0] v; logic e;
        gacc(1'b1, 'h00, 0, v, e);
        hv_load(0, mk(200, 2, 4, 1));
        @(posedge clk); #1;
        chk("R7 no virq disabled", {31'd0, virq}, 32'd0);
        gacc(1'b0, 'h0C, 0, v, e);
        chk("R3 disabled ack", v, 32'd1023);
        rd_lr(0, v);
        chk("R3 entry kept", v, mk(200, 2, 4, 1));
        gacc(1'b1, 'h00, 1, v, e);
        chk("R7 one cycle after enable", {31'd0, virq}, 32'd0);
        @(posedge clk); #1;
        chk("R7 raised after enable", {31'd0, virq}, 32'd1);
        gacc(1'b1, 'h00, 0, v, e);
        @(posedge clk); #1;
        chk("R7 stays after disable", {31'd0, virq}, 32'd1);
        gacc(1'b1, 'h10, 32'd2248, v, e);
        chk("R7 low after retire", {31'd0, virq}, 32'd0);
        rd_lr(0, v);
        chk("R6 pending entry retired", v, mk(200, 2, 4, 0));
        gacc(1'b1, 'h00, 1, v, e);
    endtask

    task automatic t_hw();
        logic [31:0] v; logic e;
        hv_load(1, mk(7, 0, 0, 1, 1'b1));
        gacc(1'b0, 'h0C, 0, v, e);
        chk("R10 hw err", {31'd0, e}, 32'd1);
        chk("R10 hw data", v, 32'd0);
        rd_lr(1, v);
        chk("R10 hw state kept", v, mk(7, 0, 0, 1, 1'b1));
        hv_load(1, 32'd0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v; logic e;
        gacc(1'b0, 'h08, 0, v, e);
        chk("R11 hole read err", {31'd0, e}, 32'd1);
        chk("R11 hole read data", v, 32'd0);
        hv_load(3, mk(9, 0, 1, 1));
        gacc(1'b1, 'h0C, 0, v, e);
        chk("R11 ack write err", {31'd0, e}, 32'd1);
        gacc(1'b0, 'h10, 0, v, e);
        chk("R11 eoi read err", {31'd0, e}, 32'd1);
        gacc(1'b1, 'h20, 0, v, e);
        chk("R11 hole write err", {31'd0, e}, 32'd1);
        gacc(1'b1, 'h01, 0, v, e);
        chk("R11 misaligned err", {31'd0, e}, 32'd1);
        gacc(1'b0, 'h00, 0, v, e);
        chk("R11 enable kept", v, 32'd1);
        rd_lr(3, v);
        chk("R11 entry kept", v, mk(9, 0, 1, 1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; hv_we = 1'b0; hv_idx = '0; hv_wdata = '0; hv_ridx = '0;
        g_req = 1'b0; g_we = 1'b0; g_addr = '0; g_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_ctrl_pmask();
        t_load_virq();
        t_select();
        t_eoi();
        t_disabled();
        t_hw();
        t_unmapped();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule